// File: doc/BRIEF.md
# Power-Good Window Debounce Monitor

This block turns the digital outputs of two feedback comparators into a single registered power-good flag. One comparator reports that the feedback voltage sits above the lower limit of a ±17% band around the regulation level. The other reports that it sits below the upper limit. Each comparator output is passed through a two-flop synchronizer. The feedback counts as in-window only when both synchronized outputs are high.

Raising the flag takes a long qualification: the feedback must remain in the window for about 0.4 ms without a break. Dropping the flag takes a short qualification of about 10 µs out of the window. A return to the window during the drop timer cancels that timer, and any excursion during the rise timer restarts it from zero.

Three conditions override both timers on the next clock edge: enable low, control-supply undervoltage, and a latched overvoltage fault. Each of them forces the flag low and clears the timer. Both delays are cycle counts derived from a clock-frequency parameter.

Top module: `pgood_monitor`

## Requirements
- R1: The feedback is in-window only when `fbAboveLow` and `fbBelowHigh` are both 1. With either of them 0, the flag never rises.
- R2: From low, the flag rises after `ENTRY_CYC` consecutive synchronized in-window samples. The two synchronizer flops add 2 cycles, so a clean step into the window raises the flag at the ENTRY_CYC+2-th rising edge after the change.
- R3: Any synchronized out-of-window sample during the rise qualification restarts the count from zero.
- R4: From high, the flag falls after `EXIT_CYC` consecutive synchronized out-of-window samples, which is edge EXIT_CYC+2 after a clean step out.
- R5: A synchronized in-window sample during the drop qualification cancels it. A later excursion needs a full `EXIT_CYC` samples again.
- R6: `enable` low forces the flag low at the next rising edge and clears the timer. After `enable` returns with the feedback already in-window, the flag rises after exactly `ENTRY_CYC` edges.
- R7: `supplyUv` high forces the flag low at the next rising edge and clears the timer, with the same requalification as R6.
- R8: `ovFault` high forces the flag low at the next rising edge and holds it low for as long as `ovFault` stays high.
- R9: `rstN` low clears the flag at once (asynchronous reset) along with the synchronizer and the timer.
- R10: `ENTRY_CYC` = `CLK_HZ`/1000·`ENTRY_US`/1000 and `EXIT_CYC` = `CLK_HZ`/1000·`EXIT_US`/1000, each with a minimum of 1. The timer never counts beyond the larger of the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low forces the flag low |
| supplyUv | input | 1 | Control-supply undervoltage; high forces the flag low |
| ovFault | input | 1 | Latched overvoltage fault; high forces the flag low |
| fbAboveLow | input | 1 | Comparator: feedback above the lower window limit (asynchronous) |
| fbBelowHigh | input | 1 | Comparator: feedback below the upper window limit (asynchronous) |
| powerGood | output | 1 | Registered power-good flag |

## Verification
The bench builds the monitor with `CLK_HZ` = 1 MHz, `ENTRY_US` = 400 and `EXIT_US` = 10. This gives a 400-cycle rise qualification and a 10-cycle drop qualification. At these sizes the exact edge on which the flag moves can be checked one cycle early and one cycle on time. The restart and cancel cases place an excursion deep inside each timer, so a timer that only pauses, rather than restarting, moves the flag at a visibly wrong edge. The override cases check the one-edge response and the shorter, synchronizer-free requalification that follows when the feedback never left the window.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef struct packed {
    logic clear;
    logic bump;
  } cntCmd_t;

  typedef enum logic {
    ST_QUAL = 1'b0,
    ST_GOOD = 1'b1
  } pgState_t;
endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic stageA, stageB;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageA <= 1'b0;
        stageB <= 1'b0;
      end else begin
        stageA <= din[b];
        stageB <= stageA;
      end
    end
    assign dout[b] = stageB;
  end
endmodule

// File: rtl/pgm_datapath.sv
module pgm_datapath
  import pgm_pkg::*;
#(
  parameter int ENTRY_CYC = 20000,
  parameter int EXIT_CYC  = 500,
  parameter int CW        = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    entryDone,
  output logic    exitDone
);
  localparam int LIMIT = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (cmd.clear) cnt <= '0;
    else if (cmd.bump)  cnt <= cnt + 1'b1;
  end

  assign entryDone = (cnt == CW'(ENTRY_CYC - 1));
  assign exitDone  = (cnt == CW'(EXIT_CYC - 1));

  // R10: the timer stays inside the longer qualification window
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(LIMIT - 1));

  p_cmd_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.clear && cmd.bump));
endmodule

// File: rtl/pgm_control.sv
module pgm_control
  import pgm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    supplyUv,
  input  logic    ovFault,
  input  logic    inWin,
  input  logic    entryDone,
  input  logic    exitDone,
  output cntCmd_t cmd,
  output logic    powerGood
);
  pgState_t state, nextState;
  logic kill;

  assign kill = !enable || supplyUv || ovFault;

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (kill) begin
      nextState = ST_QUAL;
      cmd.clear = 1'b1;
    end else begin
      case (state)
        ST_QUAL: begin
          if (!inWin) cmd.clear = 1'b1;
          else if (entryDone) begin
            nextState = ST_GOOD;
            cmd.clear = 1'b1;
          end else cmd.bump = 1'b1;
        end
        ST_GOOD: begin
          if (inWin) cmd.clear = 1'b1;
          else if (exitDone) begin
            nextState = ST_QUAL;
            cmd.clear = 1'b1;
          end else cmd.bump = 1'b1;
        end
        default: begin
          nextState = ST_QUAL;
          cmd.clear = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_QUAL;
    else       state <= nextState;
  end

  assign powerGood = (state == ST_GOOD);

  p_en_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !powerGood);
  p_uv_r7: assert property (@(posedge clk) disable iff (!rstN)
    supplyUv |=> !powerGood);
  p_ov_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovFault |=> !powerGood);
  // R1 / R2: a rise only follows an in-window sample with no override
  p_rise_in_win_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> ($past(inWin) && !$past(kill)));
  // R4: a fall needs an out-of-window sample or an override
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerGood) |-> (!$past(inWin) || $past(kill)));
endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor
  import pgm_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int ENTRY_US = 400,
  parameter int EXIT_US  = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic supplyUv,
  input  logic ovFault,
  input  logic fbAboveLow,
  input  logic fbBelowHigh,
  output logic powerGood
);
  localparam int KHZ       = CLK_HZ / 1000;
  localparam int ENTRY_RAW = KHZ * ENTRY_US / 1000;
  localparam int EXIT_RAW  = KHZ * EXIT_US / 1000;
  localparam int ENTRY_CYC = (ENTRY_RAW > 0) ? ENTRY_RAW : 1;
  localparam int EXIT_CYC  = (EXIT_RAW > 0) ? EXIT_RAW : 1;
  localparam int MAX_CYC   = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CW        = (MAX_CYC > 1) ? $clog2(MAX_CYC + 1) : 1;

  logic [1:0] cmpSync;
  logic       inWin;
  logic       entryDone, exitDone;
  cntCmd_t    cmd;

  pgm_sync #(.W(2)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({fbBelowHigh, fbAboveLow}),
    .dout(cmpSync)
  );

  assign inWin = &cmpSync;

  pgm_datapath #(
    .ENTRY_CYC(ENTRY_CYC),
    .EXIT_CYC (EXIT_CYC),
    .CW       (CW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .entryDone(entryDone),
    .exitDone (exitDone)
  );

  pgm_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .supplyUv (supplyUv),
    .ovFault  (ovFault),
    .inWin    (inWin),
    .entryDone(entryDone),
    .exitDone (exitDone),
    .cmd      (cmd),
    .powerGood(powerGood)
  );
endmodule

// File: tb/pgood_monitor_test.sv
module pgood_monitor_test;
  localparam int E = 400;  // 1 MHz * 400 us
  localparam int X = 10;   // 1 MHz * 10 us

  typedef struct packed {
    logic en, uv, ov, above, below;
    logic [11:0] waitCyc;
    logic exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'd5,    1'b0,4'd1},  // R1 below low limit
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'(E+1), 1'b0,4'd2},  // R2 one edge early
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'd1,    1'b1,4'd2},  // R2 on time
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'(X+1), 1'b1,4'd4},  // R4 one edge early
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'd1,    1'b0,4'd4},  // R4 on time
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'd200,  1'b0,4'd3},  // R3 partial entry
    '{1'b1,1'b0,1'b0,1'b1,1'b0,12'd3,    1'b0,4'd1},  // R1 above high limit
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'(E+1), 1'b0,4'd3},  // R3 restarted count
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'd1,    1'b1,4'd3},  // R3 full entry
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'd5,    1'b1,4'd5},  // R5 partial exit
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'd5,    1'b1,4'd5},  // R5 return cancels
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'(X+1), 1'b1,4'd5},  // R5 full window again
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'd1,    1'b0,4'd5},  // R5 drops
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'(E+2), 1'b1,4'd2},  // R2 requalify
    '{1'b0,1'b0,1'b0,1'b1,1'b1,12'd1,    1'b0,4'd6},  // R6 next edge
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'(E-1), 1'b0,4'd6},  // R6 restart early
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'd1,    1'b1,4'd6},  // R6 restart on time
    '{1'b1,1'b1,1'b0,1'b1,1'b1,12'd1,    1'b0,4'd7},  // R7 next edge
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'(E-1), 1'b0,4'd7},  // R7 restart early
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'd1,    1'b1,4'd7},  // R7 restart on time
    '{1'b1,1'b0,1'b1,1'b1,1'b1,12'd1,    1'b0,4'd8},  // R8 next edge
    '{1'b1,1'b0,1'b1,1'b1,1'b1,12'(E+5), 1'b0,4'd8},  // R8 held low
    '{1'b1,1'b0,1'b0,1'b1,1'b1,12'(E),   1'b1,4'd8}   // R8 release
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, supplyUv = 1'b0, ovFault = 1'b0;
  logic fbAboveLow = 1'b0, fbBelowHigh = 1'b0;
  logic powerGood;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pgood_monitor #(.CLK_HZ(1_000_000), .ENTRY_US(400), .EXIT_US(10)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .supplyUv(supplyUv),
    .ovFault(ovFault), .fbAboveLow(fbAboveLow), .fbBelowHigh(fbBelowHigh),
    .powerGood(powerGood)
  );

  task automatic chk(input logic exp, input int req, input string what);
    total++;
    if (powerGood !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, powerGood, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R9: reset state
    tick(3);
    chk(1'b0, 9, "reset state");
    rstN = 1'b1;
    tick(1);
    chk(1'b0, 9, "after reset release");

    for (int i = 0; i < NV; i++) begin
      enable      = VECS[i].en;
      supplyUv    = VECS[i].uv;
      ovFault     = VECS[i].ov;
      fbAboveLow  = VECS[i].above;
      fbBelowHigh = VECS[i].below;
      tick(int'(VECS[i].waitCyc));
      chk(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R9: asynchronous reset while high, then full requalification
    rstN = 1'b0;
    #2;
    chk(1'b0, 9, "async reset clears flag");
    @(negedge clk);
    rstN = 1'b1;
    tick(E + 1);
    chk(1'b0, 9, "requalify early after reset");
    tick(1);
    chk(1'b1, 9, "requalify on time after reset");

    // R10: both comparators low is outside the window
    fbAboveLow = 1'b0; fbBelowHigh = 1'b0;
    tick(X + 2);
    chk(1'b0, 10, "exit timing with both comparators low");

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule